// File: doc/BRIEF.md
# Slow-Region Ready Wait Generator

This block sits beside a bus master that shares its low address byte with the data on one set of lines. It holds the low address byte in a transparent latch while the address-latch-enable strobe is high, compares the full 16-bit address (upper byte from its own lines, lower byte from the latch) against a base/mask window, and drives a chip select for the slow device found there.

The chip select also steers an 8-bit shift register clocked by the bus clock. While the select is low, the register is held at all ones, so the ready line stays high. On the first clock edge that sees the select high, the register loads a pattern whose top `WAIT_CLKS` bits are zero. Each later edge shifts it toward the output and feeds a one in at the far end. The ready line is the top stage, so it stays low for exactly `WAIT_CLKS` clocks and then returns high. A master that samples ready on the rising clock therefore stretches its cycle by that many clocks. There is no data stream here: every pin is a plain level, so no valid/ready handshake or back-pressure applies.

Top module: `slow_ready_gen`

## Requirements
- R1: While `ale` is high the latch follows `mux_bus`; while `ale` is low, changes on `mux_bus` do not change `slow_sel`.
- R2: `slow_sel` is high exactly when `({hi_addr, latched_low} & REGION_MASK) == (REGION_BASE & REGION_MASK)`. The defaults are base 16'h9A50 and mask 16'hFFF0.
- R3: While `rst_n` is low, `ready` is high.
- R4: After any clock edge at which `slow_sel` was low, `ready` is high.
- R5: Count the consecutive clock edges that have seen `slow_sel` high as k. While k is between 1 and `WAIT_CLKS`, `ready` is low.
- R6: With `WAIT_CLKS` = 0, `ready` never goes low.
- R7: If `slow_sel` drops during a wait, `ready` is high after the next clock edge.
- R8: Once k exceeds `WAIT_CLKS`, `ready` stays high for as long as `slow_sel` stays high, because ones shift into the register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock; clocks the shift register |
| rst_n | input | 1 | Asynchronous active-low reset |
| ale | input | 1 | Address latch enable; latch is transparent while high |
| mux_bus | input | 8 | Shared low-address/data lines |
| hi_addr | input | 8 | Upper address byte |
| slow_sel | output | 1 | Active-high chip select for the slow region |
| ready | output | 1 | Ready to the bus master; low inserts a wait clock |

## Verification
The properties assume that `hi_addr` and `ale` change only away from the rising clock edge. They also assume that the low address is stable on `mux_bus` whenever `ale` is high. The hold check additionally assumes that `hi_addr` stays fixed while the latch is closed. The stimulus changes every input shortly after a rising edge and raises `ale` for one whole clock with the address already present. During data phases it moves only `mux_bus`, except in the abort case, where it deliberately changes `hi_addr` to remove the select in the middle of a wait.

// File: rtl/srg_pkg.sv
package srg_pkg;
  // Pattern with the top n bits zero and the rest one; shifted toward the MSB.
  function automatic logic [7:0] wait_pattern(input int unsigned n);
    logic [7:0] p;
    p = 8'hFF >> n;
    return p;
  endfunction
endpackage

// File: rtl/srg_addr_latch.sv
module srg_addr_latch #(
  parameter int LO_W = 8
) (
  input  logic            ale,
  input  logic [LO_W-1:0] bus_in,
  output logic [LO_W-1:0] lo_q
);
  // Level-sensitive capture of the low address byte.
  always_latch begin
    if (ale) lo_q = bus_in;
  end
endmodule

// File: rtl/srg_region_decode.sv
module srg_region_decode #(
  parameter int          HI_W = 8,
  parameter int          LO_W = 8,
  parameter logic [15:0] BASE = 16'h9A50,
  parameter logic [15:0] MASK = 16'hFFF0
) (
  input  logic [HI_W-1:0] hi,
  input  logic [LO_W-1:0] lo,
  output logic            hit
);
  localparam int AW = HI_W + LO_W;
  logic [AW-1:0] full_addr;
  assign full_addr = {hi, lo};
  assign hit = ((full_addr & MASK[AW-1:0]) == (BASE[AW-1:0] & MASK[AW-1:0]));
endmodule

// File: rtl/srg_wait_shifter.sv
module srg_wait_shifter #(
  parameter int SR_W      = 8,
  parameter int WAIT_CLKS = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sel,
  output logic ready
);
  localparam logic [SR_W-1:0] ALL_ONES = {SR_W{1'b1}};
  localparam logic [SR_W-1:0] LOAD_PAT = ALL_ONES >> WAIT_CLKS;

  logic [SR_W-1:0] sr_q;
  logic            sel_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q  <= ALL_ONES;
      sel_q <= 1'b0;
    end else begin
      sel_q <= sel;
      if (!sel)
        sr_q <= ALL_ONES;                  // idle: parallel load of ones
      else if (!sel_q)
        sr_q <= LOAD_PAT;                  // select edge: load wait pattern
      else
        sr_q <= {sr_q[SR_W-2:0], 1'b1};    // shift, serial input tied high
    end
  end

  assign ready = sr_q[SR_W-1];
endmodule

// File: rtl/slow_ready_gen.sv
module slow_ready_gen #(
  parameter int          HI_W        = 8,
  parameter int          LO_W        = 8,
  parameter int          SR_W        = 8,
  parameter int          WAIT_CLKS   = 3,
  parameter logic [15:0] REGION_BASE = 16'h9A50,
  parameter logic [15:0] REGION_MASK = 16'hFFF0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ale,
  input  logic [LO_W-1:0] mux_bus,
  input  logic [HI_W-1:0] hi_addr,
  output logic            slow_sel,
  output logic            ready
);
  logic [LO_W-1:0] lo_lat;

  srg_addr_latch #(.LO_W(LO_W)) u_latch (
    .ale(ale), .bus_in(mux_bus), .lo_q(lo_lat)
  );

  srg_region_decode #(.HI_W(HI_W), .LO_W(LO_W), .BASE(REGION_BASE), .MASK(REGION_MASK)) u_dec (
    .hi(hi_addr), .lo(lo_lat), .hit(slow_sel)
  );

  srg_wait_shifter #(.SR_W(SR_W), .WAIT_CLKS(WAIT_CLKS)) u_shift (
    .clk(clk), .rst_n(rst_n), .sel(slow_sel), .ready(ready)
  );
endmodule

// File: rtl/slow_ready_gen_chk.sv
module slow_ready_gen_chk #(
  parameter int          HI_W        = 8,
  parameter int          LO_W        = 8,
  parameter int          SR_W        = 8,
  parameter int          WAIT_CLKS   = 3,
  parameter logic [15:0] REGION_BASE = 16'h9A50,
  parameter logic [15:0] REGION_MASK = 16'hFFF0
) (
  input logic            clk,
  input logic            rst_n,
  input logic            ale,
  input logic [LO_W-1:0] mux_bus,
  input logic [HI_W-1:0] hi_addr,
  input logic            slow_sel,
  input logic            ready
);
  localparam int AW = HI_W + LO_W;
  localparam int CW = $clog2(SR_W + 1) + 1;

  logic [CW-1:0] run_q;
  logic          match_now;

  assign match_now = (({hi_addr, mux_bus} & REGION_MASK[AW-1:0]) ==
                      (REGION_BASE[AW-1:0] & REGION_MASK[AW-1:0]));

  // Edges seen with the select high in the current run (saturating).
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= '0;
    else if (!slow_sel) run_q <= '0;
    else if (run_q < CW'(SR_W)) run_q <= run_q + 1'b1;
  end

  always @(negedge clk) begin
    if (!rst_n) p_reset_high_r3: assert (ready);
  end

  p_decode_open_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ale |-> (slow_sel == match_now));

  p_latch_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!ale && $past(!ale) && $stable(hi_addr)) |-> $stable(slow_sel));

  p_idle_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q == '0) |-> ready);

  p_abort_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !slow_sel |=> ready);

  p_wait_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((run_q != '0) && (run_q <= CW'(WAIT_CLKS))) |-> !ready);

  // Also covers R6: with no wait, any nonzero run needs ready high.
  p_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q > CW'(WAIT_CLKS)) |-> ready);
endmodule

bind slow_ready_gen slow_ready_gen_chk #(
  .HI_W(HI_W), .LO_W(LO_W), .SR_W(SR_W), .WAIT_CLKS(WAIT_CLKS),
  .REGION_BASE(REGION_BASE), .REGION_MASK(REGION_MASK)
) u_chk (
  .clk(clk), .rst_n(rst_n), .ale(ale), .mux_bus(mux_bus), .hi_addr(hi_addr),
  .slow_sel(slow_sel), .ready(ready)
);

// File: tb/slow_ready_gen_tb.sv
module slow_ready_gen_tb;
  localparam int N_A = 3;
  localparam int N_B = 0;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ale = 1'b0;
  logic [7:0] mux_bus = 8'h00;
  logic [7:0] hi_addr = 8'h00;
  logic       sel_a, rdy_a, sel_b, rdy_b;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;   // 50 MHz

  slow_ready_gen #(.WAIT_CLKS(N_A)) u_dut (
    .clk(clk), .rst_n(rst_n), .ale(ale), .mux_bus(mux_bus), .hi_addr(hi_addr),
    .slow_sel(sel_a), .ready(rdy_a));

  slow_ready_gen #(.WAIT_CLKS(N_B)) u_dut0 (
    .clk(clk), .rst_n(rst_n), .ale(ale), .mux_bus(mux_bus), .hi_addr(hi_addr),
    .slow_sel(sel_b), .ready(rdy_b));

  typedef struct {
    logic  sel;
    logic  rdy_a;
    logic  rdy_b;
    string tag;
  } exp_t;

  exp_t       sb_q[$];
  logic [7:0] m_lat = 8'h00;
  int         run_k = 0;

  task automatic check(input string tag, input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %b expected %b", tag, what, act, exp);
    end
  endtask

  // Driver: one cycle of stimulus plus the expected outputs for that cycle.
  task automatic step(input logic a, input logic [7:0] bus, input logic [7:0] hi, input string tag);
    exp_t e;
    logic m;
    @(posedge clk);
    #2;
    ale = a; mux_bus = bus; hi_addr = hi;
    if (a) m_lat = bus;
    m = (({hi, m_lat} & 16'hFFF0) == 16'h9A50);
    e.sel   = m;
    e.rdy_a = !(run_k >= 1 && run_k <= N_A);
    e.rdy_b = !(run_k >= 1 && run_k <= N_B);
    e.tag   = tag;
    sb_q.push_back(e);
    if (m) run_k++; else run_k = 0;
  endtask

  // Monitor: compare at the falling edge.
  initial begin
    forever begin
      @(negedge clk);
      if (sb_q.size() > 0) begin
        exp_t e;
        e = sb_q.pop_front();
        check(e.tag, sel_a, e.sel, "slow_sel");
        check(e.tag, sel_b, e.sel, "slow_sel(N=0)");
        check(e.tag, rdy_a, e.rdy_a, "ready");
        check(e.tag, rdy_b, e.rdy_b, "ready(N=0) R6");
      end
    end
  end

  initial begin
    #400_000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R3", rdy_a, 1'b1, "ready in reset");
    check("R3", rdy_b, 1'b1, "ready(N=0) in reset");
    @(posedge clk); #2; rst_n = 1'b1;

    // R4: idle, address outside region
    step(1'b1, 8'h10, 8'h12, "R4 idle");
    step(1'b0, 8'hAA, 8'h12, "R4 idle");
    step(1'b0, 8'h55, 8'h12, "R4 idle");

    // R2/R5/R8: access to 9A57, data phase moves bus (R1 hold)
    step(1'b1, 8'h57, 8'h9A, "R2 hit");
    for (int i = 0; i < 7; i++) step(1'b0, 8'h60 + 8'(i), 8'h9A, "R5/R8/R1 wait");
    step(1'b1, 8'h61, 8'h9A, "R2 miss low byte");
    step(1'b0, 8'h50, 8'h9A, "R1 closed latch");
    step(1'b0, 8'h50, 8'h9A, "R4 idle");

    // R7: abort during wait by moving the upper address
    step(1'b1, 8'h5F, 8'h9A, "R2 hit edge low");
    step(1'b0, 8'h00, 8'h9A, "R5 wait");
    step(1'b0, 8'h00, 8'h12, "R7 abort");
    step(1'b0, 8'h00, 8'h12, "R7 released");
    step(1'b0, 8'h00, 8'h12, "R4 idle");

    // second full access, upper address miss then hit
    step(1'b1, 8'h50, 8'h9B, "R2 miss hi");
    step(1'b1, 8'h50, 8'h9A, "R2 hit base");
    for (int i = 0; i < 5; i++) step(1'b0, 8'hF0, 8'h9A, "R5/R8 wait");
    step(1'b1, 8'h00, 8'h00, "R4 end");
    step(1'b0, 8'h00, 8'h00, "R4 end");

    @(negedge clk); @(negedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule